// File: doc/BRIEF.md
# Iterative Q15 Fractional Divider

This block divides two non-negative signed words and returns the ratio as a fixed-point fraction with fifteen fraction bits. The numerator must be no larger than the denominator, so the result lies in [0, 1). The block suits gain and normalisation paths that need a ratio and can tolerate a fixed latency.

A caller raises `start` for one cycle with the operands on `num` and `den`. The request is taken only while `busy` is low. A normal request runs one restoring step per round. In each step the partial remainder and the quotient shift left by one bit. The shifted remainder is then compared with the denominator, and when it is not smaller the denominator is subtracted and a one enters the quotient LSB. When the last round ends, `done` pulses for one cycle and `quot` holds the result until the next accepted request.

Two cases skip the iteration and answer in one cycle. Equal operands return the largest positive fraction. A zero denominator returns the same value and raises `div_zero`. The parameter `STEPS_PER_CYCLE` chains several steps per clock, which trades logic depth for rounds.

Top module: `frac_div`

## Requirements
- R1: An accepted request with `num == den` (den non-zero) gives `quot = 0x7FFF` and a `done` pulse in the next cycle, and `busy` never rises.
- R2: An accepted request with `den == 0` sets `div_zero` and gives `quot = 0x7FFF` with `done` in the next cycle.
- R3: For 0 <= num < den, the quotient equals floor(num * 32768 / den).
- R4: With the default of one step per cycle, `busy` is high for exactly 15 cycles after a normal request is accepted, and `done` rises in the cycle in which `busy` falls.
- R5: `done` lasts one cycle, and `quot` keeps its value while the block is idle until the next accepted request.
- R6: A `start` raised while `busy` is high is ignored. The running division finishes with its original operands.
- R7: After reset, `busy`, `done`, `div_zero` and `quot` are all zero.
- R8: A zero numerator with a non-zero, different denominator gives `quot = 0` after the full run.
- R9: `div_zero` keeps its value until the next accepted request and is cleared by a request with a non-zero denominator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken only while idle |
| num | input | W | Numerator, non-negative, not above `den` |
| den | input | W | Denominator, non-negative |
| busy | output | 1 | Division rounds in progress |
| done | output | 1 | One-cycle pulse when `quot` becomes valid |
| quot | output | W | Q15 quotient, held while idle |
| div_zero | output | 1 | Last accepted request had a zero denominator |

## Verification
Random legal operand pairs exercise the restoring step across the whole range. Each result is compared with floor(num·32768/den), so a wrong compare, a wrong subtract or an off-by-one round count shows up as a wrong quotient. Equal operands and a zero denominator are the two early exits, and each must finish in one cycle with 0x7FFF. A zero denominator must also raise the flag, and the next request must clear it. A zero numerator and near-unity ratios such as 0x7FFE/0x7FFF probe the ends of the range. A second `start` issued mid-run checks that an ongoing division cannot be overwritten.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

   typedef enum logic {
      DV_IDLE = 1'b0,
      DV_RUN  = 1'b1
   } dv_state_e;

   // quotient bits produced per operand width
   function automatic int dv_frac_bits(input int width);
      return width - 1;
   endfunction

endpackage

// File: rtl/frac_div_step.sv
module frac_div_step #(
   parameter int W = 16
) (
   input  logic [W:0]   rem_i,
   input  logic [W-1:0] q_i,
   input  logic [W-1:0] den_i,
   output logic [W:0]   rem_o,
   output logic [W-1:0] q_o
);
   localparam int SH_W = W + 2;

   logic [SH_W-1:0] shifted;
   logic            take;

   always_comb begin
      shifted = {rem_i, 1'b0};
      take    = (shifted >= SH_W'(den_i));
      rem_o   = (W+1)'(take ? (shifted - SH_W'(den_i)) : shifted);
      q_o     = {q_i[W-2:0], take};
   end

endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
   import frac_div_pkg::*;
#(
   parameter int ROUNDS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic short_i,
   output logic accept_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
   localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

   dv_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign accept_o = start && (state_q == DV_IDLE);
   assign step_o   = (state_q == DV_RUN);
   assign busy_o   = (state_q == DV_RUN);
   assign done_o   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DV_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            DV_IDLE: begin
               if (accept_o) begin
                  cnt_q <= '0;
                  if (short_i) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= DV_RUN;
                  end
               end
            end
            default: begin
               if (cnt_q == LAST) begin
                  state_q <= DV_IDLE;
                  done_q  <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/frac_div.sv
module frac_div
   import frac_div_pkg::*;
#(
   parameter int W               = 16,
   parameter int STEPS_PER_CYCLE = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quot,
   output logic         div_zero
);
   localparam int STEPS  = dv_frac_bits(W);
   localparam int ROUNDS = STEPS / STEPS_PER_CYCLE;
   localparam int REM_W  = W + 1;
   localparam logic [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};

   if (W < 4) begin : g_bad_width
      $error("frac_div: W must be at least 4");
   end
   if (STEPS_PER_CYCLE < 1 || (STEPS % STEPS_PER_CYCLE) != 0) begin : g_bad_spc
      $error("frac_div: STEPS_PER_CYCLE must divide W-1");
   end

   logic [REM_W-1:0] rem_q;
   logic [W-1:0]     q_q;
   logic [W-1:0]     den_q;
   logic             zero_q;
   logic             accept;
   logic             step;
   logic             short_c;

   assign short_c = (den == '0) || (num == den);

   frac_div_ctrl #(.ROUNDS(ROUNDS)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .short_i  (short_c),
      .accept_o (accept),
      .step_o   (step),
      .busy_o   (busy),
      .done_o   (done)
   );

   logic [REM_W-1:0] rem_ch [STEPS_PER_CYCLE+1];
   logic [W-1:0]     q_ch   [STEPS_PER_CYCLE+1];

   assign rem_ch[0] = rem_q;
   assign q_ch[0]   = q_q;

   for (genvar g = 0; g < STEPS_PER_CYCLE; g++) begin : g_chain
      frac_div_step #(.W(W)) i_step (
         .rem_i (rem_ch[g]),
         .q_i   (q_ch[g]),
         .den_i (den_q),
         .rem_o (rem_ch[g+1]),
         .q_o   (q_ch[g+1])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         den_q  <= '0;
         zero_q <= 1'b0;
      end else if (accept) begin
         zero_q <= (den == '0);
         den_q  <= den;
         if (short_c) begin
            q_q <= Q_MAX;
         end else begin
            rem_q <= {num[W-1], num};
            q_q   <= '0;
         end
      end else if (step) begin
         rem_q <= rem_ch[STEPS_PER_CYCLE];
         q_q   <= q_ch[STEPS_PER_CYCLE];
      end
   end

   assign quot     = q_q;
   assign div_zero = zero_q;

endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [W-1:0] num,
   input logic [W-1:0] den,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] quot,
   input logic         div_zero
);
   localparam logic [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};

   p_equal_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && num == den && den != '0) |=> (done && !busy && quot == Q_MAX));

   p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && den == '0) |=> (div_zero && done && quot == Q_MAX));

   p_run_ends_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_quot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(quot));

   p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || !start) |=> $stable(div_zero));

endmodule

bind frac_div frac_div_chk #(.W(W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .num      (num),
   .den      (den),
   .busy     (busy),
   .done     (done),
   .quot     (quot),
   .div_zero (div_zero)
);

// File: tb/test_frac_div.sv
module test_frac_div;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] num = '0;
   logic [W-1:0] den = '0;
   logic         busy, done, div_zero;
   logic [W-1:0] quot;

   always #5 clk = ~clk;

   frac_div #(.W(W), .STEPS_PER_CYCLE(1)) i_frac_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .num      (num),
      .den      (den),
      .busy     (busy),
      .done     (done),
      .quot     (quot),
      .div_zero (div_zero)
   );

   // behavioural reference model, advanced on each rising edge
   logic         m_busy = 1'b0, m_done = 1'b0, m_zero = 1'b0;
   logic [W-1:0] m_quot = '0;
   int           m_left = 0;
   longint       m_pend = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0; m_done <= 1'b0; m_zero <= 1'b0;
         m_quot <= '0;   m_left <= 0;
      end else begin
         m_done <= 1'b0;
         if (!m_busy && start) begin
            m_zero <= (den == 0);
            if (den == 0 || num == den) begin
               m_quot <= 16'h7FFF;
               m_done <= 1'b1;
            end else begin
               m_busy <= 1'b1;
               m_left <= 15;
               m_pend <= (longint'(num) * 32768) / longint'(den);
            end
         end else if (m_busy) begin
            if (m_left == 1) begin
               m_busy <= 1'b0;
               m_done <= 1'b1;
               m_quot <= W'(m_pend);
            end
            m_left <= m_left - 1;
         end
      end
   end

   int    checks = 0;
   int    failures = 0;
   string tag = "R7";
   bit    finished = 1'b0;
   int    wd = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare the design with the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk((tag == "R7") ? "R7" : "R4", "busy", busy, m_busy);
         chk((tag == "R7") ? "R7" : "R5", "done", done, m_done);
         chk((tag == "R2" || tag == "R9" || tag == "R7") ? tag : "R9", "div_zero", div_zero, m_zero);
         if (!m_busy)
            chk((tag == "R1" || tag == "R2" || tag == "R6" || tag == "R7" || tag == "R8") ? tag : "R3",
                "quot", quot, m_quot);
      end
      wd++;
      if (wd > 150000 && !finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_op(input logic [W-1:0] n, input logic [W-1:0] d, input string t);
      @(negedge clk);
      tag = t; start = 1'b1; num = n; den = d;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);   // R7: reset state compared against model zeros

      run_op(16'h1234, 16'h1234, "R1");
      run_op(16'h7FFF, 16'h7FFF, "R1");
      run_op(16'h0000, 16'h0000, "R2");
      run_op(16'h0000, 16'h0100, "R9");   // clears the zero flag
      run_op(16'h0000, 16'h0000, "R2");
      run_op(16'h0005, 16'h0007, "R9");
      run_op(16'h0000, 16'h4321, "R8");
      run_op(16'h0001, 16'h7FFF, "R3");
      run_op(16'h7FFE, 16'h7FFF, "R3");
      run_op(16'h0001, 16'h0002, "R3");
      run_op(16'h2AAA, 16'h7FFF, "R3");

      // R6: a second request during the run must not disturb it
      @(negedge clk);
      tag = "R6"; start = 1'b1; num = 16'h0003; den = 16'h0009;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; num = 16'h0000; den = 16'h0000;
      @(negedge clk);
      start = 1'b0; num = 16'h0001; den = 16'h0001;
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      @(negedge clk);

      // R5: quotient held while idle for several cycles
      tag = "R5";
      repeat (6) @(negedge clk);

      for (int k = 0; k < 60; k++) begin
         logic [W-1:0] d;
         logic [W-1:0] n;
         d = W'($urandom_range(1, 32767));
         n = W'($urandom_range(0, int'(d) - 1));
         run_op(n, d, "R3");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule